// File: doc/BRIEF.md
# Dual Divider Bank Clock Crosspoint

This block produces six output clocks from two incoming clocks: a reference clock and a synthesized clock. Both arrive as plain levels sampled in one fast system clock domain. Two divider banks each pick one of the two clocks as their input. Each bank divides it by a programmable integer and also drives two fixed-ratio taps. Bank A has taps of /2 and /3. Bank B has taps of /2 and /4. A crosspoint then lets every output independently choose one of seven sources: the undivided reference, or one of the six bank products.

Configuration arrives as static fields: two divisors, two bank input selects and a 3-bit source code per output. The block checks these fields against the legality rules. A fixed tap stays phase-locked to its bank only when the divisor is a suitable multiple of the tap ratio. For that reason the taps restart at every bank terminal count, and a tap is usable only under a divisibility rule. An output whose choice breaks a rule is held low, and a sticky-free error flag reports the fault for as long as the configuration is bad. An active-low enable drives the per-output enable vector, which models the pad tri-state. An active-low power-down halts and restarts the dividers and forces every output low.

There is no streaming data path. Every pin is a plain level control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `clkx_top`

## Requirements
- R1: Output i takes its source code from `sel[3i+2:3i]`. The codes are: 0 undivided reference, 1 bank A /N, 2 bank A /2, 3 bank A /3, 4 bank B /N, 5 bank B /2, 6 bank B /4. Code 7 is reserved; it keeps that output low and raises `cfg_err`.
- R2: A bank /N output has a period of N rising edges of the bank input. It is high for ceil(N/2) of those input periods and low for floor(N/2).
- R3: Each fixed tap divides the bank input by 2, 3 or 4, with a high phase of ceil(K/2) input periods. All taps restart together with the bank's /N output at its terminal count.
- R4: A bank input select of 1 feeds that bank from the reference and 0 feeds it from the synthesized clock. A rising edge of an input that is sampled at system edge k is reflected in `clk_out` at edge k+1; this holds for the undivided reference and for the bank products alike.
- R5: A divisor is legal from 4 to 127 inclusive. A divisor outside that range raises `cfg_err` and is never loaded, so the bank keeps its last legal divisor (8 after reset). Every output that uses that bank is held low.
- R6: Bank A /2 requires N1 mod 4 = 0. Bank A /3 requires N1 = 6. Bank B /2 requires N2 mod 4 = 0. Bank B /4 requires N2 mod 8 = 0. An output that selects a tap whose rule fails is held low, and `cfg_err` is high.
- R7: A new divisor is taken only when the bank wraps at its terminal count. The period in progress completes with the old divisor.
- R8: While `oe_n` is high, `clk_oe` is all zeros one edge later. While `oe_n` is low, it is all ones.
- R9: While `pd_n` is low, all outputs are low one edge later and both banks are cleared. After release, the first rising edge of a bank's input starts a high phase using the divisor present at that moment.
- R10: Outputs that select the same legal source are equal on every system clock edge.
- R11: During reset, `clk_out`, `clk_oe` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock level |
| syn_in | input | 1 | Synthesized clock level |
| b1_src_ref | input | 1 | Bank A input select (1 reference, 0 synthesized) |
| b2_src_ref | input | 1 | Bank B input select (1 reference, 0 synthesized) |
| n1 | input | 7 | Bank A divisor |
| n2 | input | 7 | Bank B divisor |
| sel | input | 18 | Per-output source codes, 3 bits each |
| oe_n | input | 1 | Active-low output enable |
| pd_n | input | 1 | Active-low power-down |
| clk_out | output | 6 | Output clock levels |
| clk_oe | output | 6 | Per-output drive enable |
| cfg_err | output | 1 | Configuration rule violation |

## Verification
The bench builds the block with its default parameters: six outputs, 7-bit divisors, and a legal window of 4 to 127. These values put both range edges within reach. A divisor of 3 falls just below the window, and 127 is the widest odd period. They also reach every divisibility case: 6 for the /3 tap, 12, 16 and 24 for the /2 and /4 taps, and 9 for an odd period with two failing taps. A reference that rises every sixth cycle and a synthesized clock that rises every second cycle give the banks two visibly different input rates. Divisor changes made mid-period show whether the old period is finished before the new divisor applies.

// File: rtl/clkx_pkg.sv
package clkx_pkg;
  localparam int unsigned SELW = 3;
  localparam int unsigned NSRC = 8;

  typedef enum logic [SELW-1:0] {
    SRC_REF      = 3'd0,
    SRC_A_DIV    = 3'd1,
    SRC_A_HALF   = 3'd2,
    SRC_A_THIRD  = 3'd3,
    SRC_B_DIV    = 3'd4,
    SRC_B_HALF   = 3'd5,
    SRC_B_FOURTH = 3'd6,
    SRC_NONE     = 3'd7
  } src_e;
endpackage

// File: rtl/clkx_rules.sv
module clkx_rules
  import clkx_pkg::*;
#(
  parameter int NOUT    = 6,
  parameter int DW      = 7,
  parameter int DIV_MIN = 4,
  parameter int DIV_MAX = 127,
  parameter int THIRD_N = 6
) (
  input  logic [DW-1:0]        n1,
  input  logic [DW-1:0]        n2,
  input  logic [SELW*NOUT-1:0] sel,
  output logic                 n1_ok,
  output logic                 n2_ok,
  output logic [NOUT-1:0]      out_ok,
  output logic                 bad
);
  localparam logic [31:0] LO  = DIV_MIN;
  localparam logic [31:0] HI  = DIV_MAX;
  localparam logic [DW-1:0] THIRD = DW'(THIRD_N);

  logic a_half_ok, a_third_ok, b_half_ok, b_fourth_ok;

  always_comb begin
    n1_ok       = (32'(n1) >= LO) && (32'(n1) <= HI);
    n2_ok       = (32'(n2) >= LO) && (32'(n2) <= HI);
    a_half_ok   = n1_ok && (n1[1:0] == 2'b00);
    a_third_ok  = (n1 == THIRD);
    b_half_ok   = n2_ok && (n2[1:0] == 2'b00);
    b_fourth_ok = n2_ok && (n2[2:0] == 3'b000);
  end

  generate
    for (genvar i = 0; i < NOUT; i++) begin : g_out
      src_e s;
      logic ok_w;
      always_comb begin
        s = src_e'(sel[SELW*i +: SELW]);
        unique case (s)
          SRC_REF:      ok_w = 1'b1;
          SRC_A_DIV:    ok_w = n1_ok;
          SRC_A_HALF:   ok_w = a_half_ok;
          SRC_A_THIRD:  ok_w = a_third_ok;
          SRC_B_DIV:    ok_w = n2_ok;
          SRC_B_HALF:   ok_w = b_half_ok;
          SRC_B_FOURTH: ok_w = b_fourth_ok;
          default:      ok_w = 1'b0;
        endcase
      end
      assign out_ok[i] = ok_w;
    end
  endgenerate

  assign bad = ~(&out_ok) | ~n1_ok | ~n2_ok;
endmodule

// File: rtl/clkx_bank.sv
module clkx_bank #(
  parameter int DW      = 7,
  parameter int DIV_RST = 8,
  parameter int TAP_A   = 2,
  parameter int TAP_B   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          src_rise,
  input  logic [DW-1:0] div_cfg,
  input  logic          div_cfg_ok,
  output logic          lvl_n,
  output logic [1:0]    lvl_tap
);
  localparam logic [DW-1:0] ONE     = DW'(1);
  localparam logic [DW-1:0] RST_DIV = DW'(DIV_RST);

  logic [DW-1:0] act_q, cnt_q, act_nx, cnt_nx;
  logic          fresh_q, wrap;
  logic [DW:0]   hi_len;

  // Terminal count (or first edge after halt) is the only load point.
  always_comb begin
    wrap   = fresh_q | (cnt_q == act_q - ONE);
    act_nx = (wrap && div_cfg_ok) ? div_cfg : act_q;
    cnt_nx = wrap ? '0 : cnt_q + ONE;
    hi_len = ({1'b0, act_nx} + {{DW{1'b0}}, 1'b1}) >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= RST_DIV;
      cnt_q   <= '0;
      fresh_q <= 1'b1;
      lvl_n   <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
      lvl_n   <= 1'b0;
    end else if (src_rise) begin
      act_q   <= act_nx;
      cnt_q   <= cnt_nx;
      fresh_q <= 1'b0;
      lvl_n   <= ({1'b0, cnt_nx} < hi_len);
    end
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_tap
      localparam int K  = (g == 0) ? TAP_A : TAP_B;
      localparam int TW = (K > 2) ? $clog2(K) : 1;
      localparam logic [TW-1:0] LAST = TW'(K - 1);
      localparam logic [TW-1:0] HIGH = TW'((K + 1) / 2);
      logic [TW-1:0] t_q, t_nx;
      logic          lvl_q;

      always_comb t_nx = (wrap || t_q == LAST) ? '0 : t_q + TW'(1);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          t_q   <= '0;
          lvl_q <= 1'b0;
        end else if (!run) begin
          t_q   <= '0;
          lvl_q <= 1'b0;
        end else if (src_rise) begin
          t_q   <= t_nx;
          lvl_q <= (t_nx < HIGH);
        end
      end
      assign lvl_tap[g] = lvl_q;
    end
  endgenerate
endmodule

// File: rtl/clkx_xbar.sv
module clkx_xbar
  import clkx_pkg::*;
#(
  parameter int NOUT = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [NSRC-1:0]      src_lvl,
  input  logic [SELW*NOUT-1:0] sel,
  input  logic [NOUT-1:0]      out_ok,
  output logic [NOUT-1:0]      clk_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_out <= '0;
    end else begin
      for (int i = 0; i < NOUT; i++)
        clk_out[i] <= run & out_ok[i] & src_lvl[sel[SELW*i +: SELW]];
    end
  end
endmodule

// File: rtl/clkx_top.sv
module clkx_top
  import clkx_pkg::*;
#(
  parameter int NOUT     = 6,
  parameter int DW       = 7,
  parameter int DIV_MIN  = 4,
  parameter int DIV_MAX  = 127,
  parameter int DIV_IDLE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_in,
  input  logic                 syn_in,
  input  logic                 b1_src_ref,
  input  logic                 b2_src_ref,
  input  logic [DW-1:0]        n1,
  input  logic [DW-1:0]        n2,
  input  logic [SELW*NOUT-1:0] sel,
  input  logic                 oe_n,
  input  logic                 pd_n,
  output logic [NOUT-1:0]      clk_out,
  output logic [NOUT-1:0]      clk_oe,
  output logic                 cfg_err
);
  logic ref_d, syn_d, ref_rise, syn_rise, ref_lvl_q;
  logic a_rise, b_rise, a_n, b_n, n1_ok, n2_ok, bad;
  logic [1:0] a_tap, b_tap;
  logic [NOUT-1:0] out_ok;
  logic [NSRC-1:0] src_lvl;

  assign ref_rise = ref_in & ~ref_d;
  assign syn_rise = syn_in & ~syn_d;
  assign a_rise   = b1_src_ref ? ref_rise : syn_rise;
  assign b_rise   = b2_src_ref ? ref_rise : syn_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d     <= 1'b0;
      syn_d     <= 1'b0;
      ref_lvl_q <= 1'b0;
      clk_oe    <= '0;
      cfg_err   <= 1'b0;
    end else begin
      ref_d     <= ref_in;
      syn_d     <= syn_in;
      ref_lvl_q <= pd_n & ref_in;
      clk_oe    <= {NOUT{~oe_n}};
      cfg_err   <= bad;
    end
  end

  clkx_rules #(.NOUT(NOUT), .DW(DW), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_rules (
    .n1(n1), .n2(n2), .sel(sel), .n1_ok(n1_ok), .n2_ok(n2_ok),
    .out_ok(out_ok), .bad(bad)
  );

  clkx_bank #(.DW(DW), .DIV_RST(DIV_IDLE), .TAP_A(2), .TAP_B(3)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .run(pd_n), .src_rise(a_rise),
    .div_cfg(n1), .div_cfg_ok(n1_ok), .lvl_n(a_n), .lvl_tap(a_tap)
  );

  clkx_bank #(.DW(DW), .DIV_RST(DIV_IDLE), .TAP_A(2), .TAP_B(4)) u_bank_b (
    .clk(clk), .rst_n(rst_n), .run(pd_n), .src_rise(b_rise),
    .div_cfg(n2), .div_cfg_ok(n2_ok), .lvl_n(b_n), .lvl_tap(b_tap)
  );

  always_comb begin
    src_lvl               = '0;
    src_lvl[SRC_REF]      = ref_lvl_q;
    src_lvl[SRC_A_DIV]    = a_n;
    src_lvl[SRC_A_HALF]   = a_tap[0];
    src_lvl[SRC_A_THIRD]  = a_tap[1];
    src_lvl[SRC_B_DIV]    = b_n;
    src_lvl[SRC_B_HALF]   = b_tap[0];
    src_lvl[SRC_B_FOURTH] = b_tap[1];
  end

  clkx_xbar #(.NOUT(NOUT)) u_xbar (
    .clk(clk), .rst_n(rst_n), .run(pd_n), .src_lvl(src_lvl),
    .sel(sel), .out_ok(out_ok), .clk_out(clk_out)
  );
endmodule

// File: rtl/clkx_chk.sv
module clkx_chk #(
  parameter int NOUT = 6,
  parameter int DW   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DW-1:0]     n1,
  input logic [DW-1:0]     n2,
  input logic [3*NOUT-1:0] sel,
  input logic              oe_n,
  input logic              pd_n,
  input logic [NOUT-1:0]   clk_out,
  input logic [NOUT-1:0]   clk_oe,
  input logic              cfg_err
);
  assert_pd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (clk_out == '0));

  assert_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> (clk_oe == '0));

  assert_oe_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> (clk_oe == '1));

  assert_range_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (n1 < DW'(4) || n2 < DW'(4)) |=> cfg_err);

  generate
    for (genvar i = 0; i < NOUT; i++) begin : g_o
      assert_reserved_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[3*i +: 3] == 3'd7) |=> (!clk_out[i] && cfg_err));

      assert_third_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[3*i +: 3] == 3'd3 && n1 != DW'(6)) |=> (!clk_out[i] && cfg_err));

      for (genvar j = i + 1; j < NOUT; j++) begin : g_p
        assert_same_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
          (sel[3*i +: 3] == sel[3*j +: 3]) |=> (clk_out[i] == clk_out[j]));
      end
    end
  endgenerate
endmodule

bind clkx_top clkx_chk #(.NOUT(NOUT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .n1(n1), .n2(n2), .sel(sel), .oe_n(oe_n),
  .pd_n(pd_n), .clk_out(clk_out), .clk_oe(clk_oe), .cfg_err(cfg_err)
);

// File: tb/tb_clkx_top.sv
module tb_clkx_top;
  localparam int NOUT = 6;
  localparam int DW   = 7;

  logic clk = 0, rst_n = 0, ref_in = 0, syn_in = 0;
  logic b1_src_ref = 0, b2_src_ref = 0, oe_n = 0, pd_n = 1;
  logic [DW-1:0] n1 = 7'd8, n2 = 7'd8;
  logic [3*NOUT-1:0] sel = '0;
  logic [NOUT-1:0] clk_out, clk_oe;
  logic cfg_err;

  always #5 clk = ~clk;

  clkx_top dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .syn_in(syn_in),
    .b1_src_ref(b1_src_ref), .b2_src_ref(b2_src_ref), .n1(n1), .n2(n2),
    .sel(sel), .oe_n(oe_n), .pd_n(pd_n), .clk_out(clk_out),
    .clk_oe(clk_oe), .cfg_err(cfg_err)
  );

  int checks = 0, errors = 0, pc = 0;
  bit done = 0, same_chk = 0;
  string ptag = "";

  typedef struct { int due; bit [6:0] lv; } item_t;
  item_t q[$];

  // independent reference model state
  int  m_cnt[2], m_act[2], m_t[2][2];
  bit  m_fresh[2];
  bit  m_lv[2][3];
  bit  m_ref_prev, m_syn_prev;
  int  tapk[2][2] = '{'{2, 3}, '{2, 4}};
  int  rph = 0, sph = 0;
  localparam int RP = 6, SP = 2;

  always @(posedge clk) pc++;

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", tag, what, act, exp, pc);
    end
  endtask

  function automatic bit in_rng(input int n);
    return n >= 4 && n <= 127;
  endfunction

  function automatic bit legal(input int s);
    case (s)
      0: return 1;
      1: return in_rng(n1);
      2: return in_rng(n1) && (n1 % 4 == 0);
      3: return n1 == 6;
      4: return in_rng(n2);
      5: return in_rng(n2) && (n2 % 4 == 0);
      6: return in_rng(n2) && (n2 % 8 == 0);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_for(input int s, input bit ok);
    if (ptag != "") return ptag;
    if (s == 7) return "R1";
    if (!ok) return ((s >= 1 && s <= 3 && !in_rng(n1)) || (s >= 4 && !in_rng(n2))) ? "R5" : "R6";
    if (s == 0) return "R4";
    if (s == 1 || s == 4) return "R2";
    return "R3";
  endfunction

  // monitor: pops expected source levels and compares the outputs
  always @(negedge clk) begin
    item_t it;
    bit allok;
    while (q.size() > 0 && q[0].due < pc) void'(q.pop_front());
    if (!done && q.size() > 0 && q[0].due == pc) begin
      it = q.pop_front();
      allok = 1;
      for (int i = 0; i < NOUT; i++) begin
        int s;
        bit ok, e;
        s = int'(sel[3*i +: 3]);
        ok = legal(s);
        allok &= ok;
        e = (pd_n && ok) ? it.lv[s] : 1'b0;
        chk(int'(clk_out[i]), int'(e), tag_for(s, ok), $sformatf("clk_out[%0d]", i));
      end
      chk(int'(cfg_err), int'(!(allok && in_rng(n1) && in_rng(n2))),
          (in_rng(n1) && in_rng(n2)) ? "R6" : "R5", "cfg_err");
      chk(int'(clk_oe), oe_n ? 0 : 63, "R8", "clk_oe");
      if (same_chk)
        for (int i = 1; i < NOUT; i++)
          chk(int'(clk_out[i]), int'(clk_out[0]), "R10", "same-source output");
    end
  end

  task automatic model_reset();
    for (int b = 0; b < 2; b++) begin
      m_cnt[b] = 0; m_act[b] = 8; m_fresh[b] = 1;
      m_t[b][0] = 0; m_t[b][1] = 0;
      for (int k = 0; k < 3; k++) m_lv[b][k] = 0;
    end
    m_ref_prev = 0; m_syn_prev = 0;
  endtask

  task automatic model_step();
    bit rr, sr;
    item_t it;
    rr = ref_in && !m_ref_prev;
    sr = syn_in && !m_syn_prev;
    m_ref_prev = ref_in;
    m_syn_prev = syn_in;
    for (int b = 0; b < 2; b++) begin
      bit rise;
      int cfg;
      rise = ((b == 0) ? b1_src_ref : b2_src_ref) ? rr : sr;
      cfg  = (b == 0) ? int'(n1) : int'(n2);
      if (!pd_n) begin
        m_fresh[b] = 1; m_cnt[b] = 0;
        m_t[b][0] = 0; m_t[b][1] = 0;
        for (int k = 0; k < 3; k++) m_lv[b][k] = 0;
      end else if (rise) begin
        if (m_fresh[b] || m_cnt[b] == m_act[b] - 1) begin
          if (in_rng(cfg)) m_act[b] = cfg;
          m_cnt[b] = 0;
          m_t[b][0] = 0; m_t[b][1] = 0;
        end else begin
          m_cnt[b]++;
          for (int k = 0; k < 2; k++)
            m_t[b][k] = (m_t[b][k] == tapk[b][k] - 1) ? 0 : m_t[b][k] + 1;
        end
        m_fresh[b] = 0;
        m_lv[b][0] = m_cnt[b] < (m_act[b] + 1) / 2;
        for (int k = 0; k < 2; k++)
          m_lv[b][k+1] = m_t[b][k] < (tapk[b][k] + 1) / 2;
      end
    end
    it.due = pc + 2;
    it.lv  = {m_lv[1][2], m_lv[1][1], m_lv[1][0],
              m_lv[0][2], m_lv[0][1], m_lv[0][0], pd_n & ref_in};
    q.push_back(it);
  endtask

  // driver: the first half opens a cycle for config edits, the second
  // half advances the source clocks and pushes the expected item
  task automatic tick_begin();
    @(negedge clk);
    #1;
  endtask

  task automatic tick_end();
    rph = (rph + 1) % RP;
    sph = (sph + 1) % SP;
    ref_in = (rph < RP / 2);
    syn_in = (sph < SP / 2);
    if (rst_n) model_step();
  endtask

  task automatic run(input int n);
    repeat (n) begin tick_begin(); tick_end(); end
  endtask

  function automatic logic [3*NOUT-1:0] pack6(input int a, b, c, d, e, f);
    return {3'(f), 3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(int'(clk_out), 0, "R11", "clk_out in reset");
    chk(int'(clk_oe), 0, "R11", "clk_oe in reset");
    chk(int'(cfg_err), 0, "R11", "cfg_err in reset");

    // R2 R3 R4: all legal taps, bank A on synthesized, bank B on reference
    tick_begin();
    n1 = 7'd12; n2 = 7'd16; b1_src_ref = 0; b2_src_ref = 1;
    sel = pack6(0, 1, 2, 4, 5, 6);
    rst_n = 1; model_reset();
    tick_end();
    run(250);

    // R3 /3 tap with N1 = 6, odd N2 = 9 breaks both bank B taps (R6)
    tick_begin();
    n1 = 7'd6; n2 = 7'd9; b1_src_ref = 1;
    sel = pack6(0, 1, 3, 4, 5, 6);
    tick_end();
    run(250);

    // R7: divisor changes mid-period take effect at terminal count
    tick_begin();
    ptag = "R7"; n1 = 7'd8; n2 = 7'd16; b1_src_ref = 0;
    sel = pack6(1, 2, 4, 5, 6, 0);
    tick_end();
    run(60);
    tick_begin(); n1 = 7'd20; tick_end();
    run(150);
    tick_begin(); n2 = 7'd24; tick_end();
    run(200);
    ptag = "";

    // R5 below-range divisor, R1 reserved code, top of range N2 = 127
    tick_begin();
    n1 = 7'd3; n2 = 7'd127;
    sel = pack6(7, 1, 2, 4, 5, 6);
    tick_end();
    run(900);

    // R8 output enable
    tick_begin();
    n1 = 7'd12; n2 = 7'd16; sel = pack6(0, 1, 2, 4, 5, 6); oe_n = 1;
    tick_end();
    run(30);
    tick_begin(); oe_n = 0; tick_end();
    run(30);

    // R9 power-down and restart
    tick_begin(); ptag = "R9"; pd_n = 0; tick_end();
    run(40);
    tick_begin(); pd_n = 1; tick_end();
    run(150);
    ptag = "";

    // R10 shared sources
    tick_begin(); same_chk = 1; n1 = 7'd10; sel = pack6(1, 1, 1, 1, 1, 1); tick_end();
    run(100);
    tick_begin(); sel = pack6(5, 5, 5, 5, 5, 5); tick_end();
    run(100);

    run(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (pc > 60000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual %0d cycles expected completion", pc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule